// File: doc/BRIEF.md
# Windowed Interrupt Routing Register File

This block is the programming face of an interrupt router. Software sees only two bus locations. One is an 8-bit select register. The other is a 32-bit data window. The select value picks which internal word the window reaches: an identification word, a version word, an arbitration word that mirrors the identification value, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin.

The block decodes every routing entry into its fields and drives them on parallel outputs for the delivery logic next to it: vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. When a window write flips a pin's mask bit, the block raises a one-cycle notice for that pin that carries the new mask value. The delivery logic can mark a level-triggered pin as accepted through a per-pin strobe, which sets the entry's remote-request flag. A write to the low half of that entry clears the flag again.

Top module: `winreg_intc`

## Requirements
- R1: A write to bus offset 0x00 stores bits 7:0 of the write data as the select value, and the upper bits are dropped. A read of offset 0x00 returns the select value in bits 7:0 with zeros above.
- R2: With select 0x01 the window reads (NPINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes at select 0x01 change nothing.
- R3: With select 0x00 the window reads the 4-bit identification value in bits 27:24, and a window write there loads it from write bits 27:24. Select 0x02 reads the same word, and window writes at select 0x02 are ignored.
- R4: A select value s of 0x10 or above addresses entry (s-0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32. Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-request 14, trigger 15 (1 = level), mask 16, destination 63:56. Each field appears on its per-pin output one cycle after the write.
- R5: A window write to an entry's low half forces that entry's remote-request bit to 0, whatever the written bit 14. A write to the high half leaves bits 31:0 unchanged.
- R6: A window write is ignored when the computed entry number is NPINS or more, or when select is 0x03 to 0x0F. The last entry (number NPINS-1) is writable.
- R7: Reset sets every entry to mask=1 with all other bits 0, and clears the select value and the identification value.
- R8: The cycle after a low-half write that changes a pin's mask bit, that pin's notice bit is 1 for exactly one cycle and its value bit equals the new mask. A write that keeps the mask raises no notice.
- R9: Reads of any bus offset other than 0x00 and 0x10 return 0, and writes to them change no state.
- R10: Read data is registered. It shows the addressed value on the cycle after the read strobe and holds its value while no read strobe is given.
- R11: A per-pin accept strobe sets the remote-request bit only when that entry's trigger bit is 1. A low-half write in the same cycle takes precedence and leaves the bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| accept_set | input | NPINS | Per-pin strobe that marks a level interrupt as accepted |
| pin_vector | output | NPINS*8 | Vector of each pin |
| pin_dmode | output | NPINS*3 | Delivery mode of each pin |
| pin_destmode | output | NPINS | Destination mode of each pin |
| pin_polarity | output | NPINS | Polarity of each pin |
| pin_trigger | output | NPINS | Trigger mode of each pin, 1 = level |
| pin_mask | output | NPINS | Mask of each pin |
| pin_dest | output | NPINS*8 | Destination of each pin |
| mchg_pulse | output | NPINS | One-cycle mask-change notice |
| mchg_val | output | NPINS | New mask value that goes with the notice |

## Verification
If the select value or the even/odd decode is wrong, the next window write lands in the wrong half or the wrong entry. The per-pin field outputs show this one cycle later, and a readback through the window shows it one cycle after the read strobe. A stuck remote-request bit shows only through a window read of the low half, so every accept and every low-half write is followed by such a read. If the mask-change logic is wrong, a notice is missing, extra, or carries the wrong value in the cycle right after the write.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  typedef enum logic [2:0] {
    WK_ID,
    WK_VER,
    WK_ARB,
    WK_ENT,
    WK_NONE
  } win_kind_e;

  localparam int unsigned B_VEC_LO   = 0;
  localparam int unsigned B_DMODE_LO = 8;
  localparam int unsigned B_DESTMODE = 11;
  localparam int unsigned B_POL      = 13;
  localparam int unsigned B_RIRR     = 14;
  localparam int unsigned B_TRIG     = 15;
  localparam int unsigned B_MASK     = 16;
  localparam int unsigned B_DEST_LO  = 56;
  localparam logic [63:0] ENTRY_RST  = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/winreg_decode.sv
module winreg_decode
  import winreg_pkg::*;
#(
  parameter int unsigned NPINS = 24
) (
  input  logic [7:0]  sel,
  output win_kind_e   kind,
  output logic [7:0]  ent_idx,
  output logic        hi_half
);
  logic [7:0] offs;

  always_comb begin
    offs    = sel - 8'h10;
    ent_idx = {1'b0, offs[7:1]};
    hi_half = sel[0];
    if (sel == 8'h00)      kind = WK_ID;
    else if (sel == 8'h01) kind = WK_VER;
    else if (sel == 8'h02) kind = WK_ARB;
    else if (sel >= 8'h10 && 32'(ent_idx) < NPINS) kind = WK_ENT;
    else                   kind = WK_NONE;
  end
endmodule

// File: rtl/winreg_entry.sv
module winreg_entry
  import winreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        accept,
  output logic [63:0] ent_q,
  output logic        mchg_pulse,
  output logic        mchg_val
);
  logic [63:0] ent_d;
  logic        pulse_d;
  logic        val_d;
  logic        ent_en;

  always_comb begin
    ent_d = ent_q;
    if (accept && ent_q[B_TRIG]) ent_d[B_RIRR] = 1'b1;
    if (wr_hi) ent_d[63:32] = wdata;
    if (wr_lo) begin
      ent_d[31:0]   = wdata;
      ent_d[B_RIRR] = 1'b0;
    end
    ent_en  = wr_lo | wr_hi | accept;
    pulse_d = wr_lo && (wdata[B_MASK] != ent_q[B_MASK]);
    val_d   = wr_lo ? wdata[B_MASK] : mchg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q      <= ENTRY_RST;
      mchg_pulse <= 1'b0;
      mchg_val   <= 1'b1;
    end else begin
      if (ent_en) ent_q <= ent_d;
      mchg_pulse <= pulse_d;
      mchg_val   <= val_d;
    end
  end
endmodule

// File: rtl/winreg_intc.sv
module winreg_intc
  import winreg_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  VERSION = 8'h11,
  parameter logic [ADDR_W-1:0] SEL_OFF = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFF = 'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    accept_set,
  output logic [NPINS*8-1:0]  pin_vector,
  output logic [NPINS*3-1:0]  pin_dmode,
  output logic [NPINS-1:0]    pin_destmode,
  output logic [NPINS-1:0]    pin_polarity,
  output logic [NPINS-1:0]    pin_trigger,
  output logic [NPINS-1:0]    pin_mask,
  output logic [NPINS*8-1:0]  pin_dest,
  output logic [NPINS-1:0]    mchg_pulse,
  output logic [NPINS-1:0]    mchg_val
);
  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [7:0]  TOP_PIN = 8'(NPINS - 1);

  logic [1:0]       rst_sync;
  logic             rst_q;
  logic [7:0]       sel_q, sel_d;
  logic             sel_en;
  logic [3:0]       id_q, id_d;
  logic             id_en;
  logic [31:0]      rdata_d;
  win_kind_e        kind;
  logic [7:0]       ent_idx;
  logic             hi_half;
  logic             win_wr;
  logic [IDX_W-1:0] ent_pick;
  logic [63:0]      ent_q [NPINS];
  logic [63:0]      ent_rd;
  logic [31:0]      win_word;
  logic [NPINS-1:0] rirr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  winreg_decode #(.NPINS(NPINS)) u_dec (
    .sel     (sel_q),
    .kind    (kind),
    .ent_idx (ent_idx),
    .hi_half (hi_half)
  );

  assign win_wr   = bus_wr && (bus_addr == WIN_OFF);
  assign ent_pick = ent_idx[IDX_W-1:0];

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic hit;
    assign hit = win_wr && (kind == WK_ENT) && (32'(ent_idx) == g);
    winreg_entry u_entry (
      .clk        (clk),
      .rst_n      (rst_q),
      .wr_lo      (hit && !hi_half),
      .wr_hi      (hit && hi_half),
      .wdata      (bus_wdata),
      .accept     (accept_set[g]),
      .ent_q      (ent_q[g]),
      .mchg_pulse (mchg_pulse[g]),
      .mchg_val   (mchg_val[g])
    );
    assign pin_vector[g*8 +: 8] = ent_q[g][B_VEC_LO +: 8];
    assign pin_dmode[g*3 +: 3]  = ent_q[g][B_DMODE_LO +: 3];
    assign pin_destmode[g]      = ent_q[g][B_DESTMODE];
    assign pin_polarity[g]      = ent_q[g][B_POL];
    assign pin_trigger[g]       = ent_q[g][B_TRIG];
    assign pin_mask[g]          = ent_q[g][B_MASK];
    assign pin_dest[g*8 +: 8]   = ent_q[g][B_DEST_LO +: 8];
    assign rirr_vec[g]          = ent_q[g][B_RIRR];
  end

  always_comb begin
    ent_rd = (kind == WK_ENT) ? ent_q[ent_pick] : 64'h0;
    case (kind)
      WK_ID, WK_ARB: win_word = {4'h0, id_q, 24'h0};
      WK_VER:        win_word = {8'h0, TOP_PIN, 8'h0, VERSION};
      WK_ENT:        win_word = hi_half ? ent_rd[63:32] : ent_rd[31:0];
      default:       win_word = 32'h0;
    endcase
    if (bus_addr == SEL_OFF)      rdata_d = {24'h0, sel_q};
    else if (bus_addr == WIN_OFF) rdata_d = win_word;
    else                          rdata_d = 32'h0;
    sel_en = bus_wr && (bus_addr == SEL_OFF);
    sel_d  = bus_wdata[7:0];
    id_en  = win_wr && (kind == WK_ID);
    id_d   = bus_wdata[27:24];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q     <= 8'h00;
      id_q      <= 4'h0;
      bus_rdata <= 32'h0;
    end else begin
      if (sel_en) sel_q     <= sel_d;
      if (id_en)  id_q      <= id_d;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/winreg_intc_chk.sv
module winreg_intc_chk #(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFF = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFF = 'h10
) (
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [7:0]        sel_q,
  input logic [NPINS-1:0]  rirr_vec,
  input logic [NPINS-1:0]  pin_mask,
  input logic [NPINS-1:0]  mchg_pulse,
  input logic [NPINS-1:0]  mchg_val
);
  logic [7:0] lo_idx;
  logic       lo_wr;

  always_comb begin
    lo_idx = 8'(sel_q - 8'h10) >> 1;
    lo_wr  = bus_wr && (bus_addr == WIN_OFF) && (sel_q >= 8'h10) &&
             !sel_q[0] && (32'(lo_idx) < NPINS);
  end

  a_r1_sel_low_byte: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_addr == SEL_OFF) |=> (sel_q == $past(bus_wdata[7:0])));

  a_r5_low_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_q)
    lo_wr |=> !rirr_vec[$past(lo_idx)]);

  a_r8_notice_carries_mask: assert property (@(posedge clk) disable iff (!rst_q)
    ((mchg_val ^ pin_mask) & mchg_pulse) == '0);

  a_r8_single_notice: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(mchg_pulse));

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind winreg_intc winreg_intc_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)
) u_chk (
  .clk(clk), .rst_q(rst_q), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sel_q(sel_q), .rirr_vec(rirr_vec), .pin_mask(pin_mask),
  .mchg_pulse(mchg_pulse), .mchg_val(mchg_val)
);

// File: tb/sim_winreg_intc.sv
module sim_winreg_intc;
  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        bus_addr = 8'h00;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_wdata = 32'h0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     accept_set = '0;
  logic [NP*8-1:0]   pin_vector, pin_dest;
  logic [NP*3-1:0]   pin_dmode;
  logic [NP-1:0]     pin_destmode, pin_polarity, pin_trigger, pin_mask;
  logic [NP-1:0]     mchg_pulse, mchg_val;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  winreg_intc #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .accept_set(accept_set), .pin_vector(pin_vector), .pin_dmode(pin_dmode),
    .pin_destmode(pin_destmode), .pin_polarity(pin_polarity),
    .pin_trigger(pin_trigger), .pin_mask(pin_mask), .pin_dest(pin_dest),
    .mchg_pulse(mchg_pulse), .mchg_val(mchg_val)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: a read strobe seen at the past edge has produced data by now
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      check(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr <= a; bus_wdata <= d; bus_wr <= 1'b1;
    @(negedge clk);
    bus_wr <= 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr <= a; bus_rd <= 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd <= 1'b0;
  endtask

  task automatic rdw(input logic [7:0] s, input logic [31:0] e, input string tag);
    wr(8'h00, {24'h0, s});
    rd(8'h10, e, tag);
  endtask

  task automatic accept(input int p);
    @(negedge clk);
    accept_set <= NP'(1) << p;
    @(negedge clk);
    accept_set <= '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    check("R7 mask all set", 64'(pin_mask), 64'({NP{1'b1}}));
    check("R7 no notice", 64'(mchg_pulse), 64'h0);
    rd(8'h00, 32'h0, "R7 select cleared");
    rdw(8'h10, 32'h0001_0000, "R7 entry0 low");
    rdw(8'h00, 32'h0, "R7 id cleared");

    // R2 version
    rdw(8'h01, 32'h0017_0011, "R2 version read");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0017_0011, "R2 version write ignored");

    // R3 identification
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hA500_0000);
    rd(8'h10, 32'h0500_0000, "R3 id write");
    rdw(8'h02, 32'h0500_0000, "R3 arb mirror");
    wr(8'h10, 32'h0F00_0000);
    rdw(8'h00, 32'h0500_0000, "R3 arb write ignored");

    // R1 select keeps low byte
    wr(8'h00, 32'h0000_1234);
    rd(8'h00, 32'h0000_0034, "R1 select low byte");

    // R4 entry 1 low half, R8 notice on unmask
    wr(8'h00, 32'h12);
    wr(8'h10, 32'h0000_AB42);
    check("R8 notice pulse", 64'(mchg_pulse), 64'(NP'(1) << 1));
    check("R8 notice value", 64'(mchg_val[1]), 64'h0);
    check("R4 vector", 64'(pin_vector[15:8]), 64'h42);
    check("R4 dmode", 64'(pin_dmode[5:3]), 64'h3);
    check("R4 destmode/pol/trig", 64'({pin_destmode[1], pin_polarity[1], pin_trigger[1]}), 64'h7);
    check("R4 mask cleared", 64'(pin_mask[1]), 64'h0);
    @(negedge clk);
    check("R8 notice one cycle", 64'(mchg_pulse), 64'h0);
    wr(8'h00, 32'h13);
    wr(8'h10, 32'hC800_0000);
    check("R4 destination", 64'(pin_dest[15:8]), 64'hC8);
    rdw(8'h12, 32'h0000_AB42, "R5 high write keeps low");
    rdw(8'h13, 32'hC800_0000, "R4 high readback");

    // R11 accept on level pin, R5 low write clears
    accept(1);
    rdw(8'h12, 32'h0000_EB42, "R11 accept sets rirr");
    wr(8'h00, 32'h13);
    wr(8'h10, 32'h1100_0000);
    rdw(8'h12, 32'h0000_EB42, "R5 high write keeps rirr");
    wr(8'h10, 32'h0000_EB42);
    check("R8 no notice when mask kept", 64'(mchg_pulse), 64'h0);
    rd(8'h10, 32'h0000_AB42, "R5 low write clears rirr");
    accept(0);
    rdw(8'h10, 32'h0001_0000, "R11 edge pin ignores accept");

    // R6 out-of-range and reserved indices
    wr(8'h00, 32'h40);
    wr(8'h10, 32'h0);
    check("R6 idx beyond pins no notice", 64'(mchg_pulse), 64'h0);
    check("R6 idx beyond pins masks kept", 64'(pin_mask), 64'({NP{1'b1}} & ~(NP'(1) << 1)));
    wr(8'h00, 32'h05);
    wr(8'h10, 32'hFFFF_FFFF);
    rdw(8'h00, 32'h0500_0000, "R6 reserved index ignored");
    wr(8'h00, 32'h3F);
    wr(8'h10, 32'hEE00_0000);
    check("R6 last entry writable", 64'(pin_dest[NP*8-1 -: 8]), 64'hEE);

    // R9 other offsets
    wr(8'h00, 32'h01);
    wr(8'h20, 32'hFF);
    rd(8'h20, 32'h0, "R9 other offset reads 0");
    rd(8'h00, 32'h01, "R9 other offset write no effect");

    // R10 hold
    rd(8'h10, 32'h0017_0011, "R10 read value");
    wr(8'h00, 32'h00);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", 64'(bus_rdata), 64'h0017_0011);

    // R8 re-mask
    wr(8'h00, 32'h12);
    wr(8'h10, 32'h0001_AB42);
    check("R8 remask notice", 64'(mchg_pulse), 64'(NP'(1) << 1));
    check("R8 remask value", 64'(mchg_val[1]), 64'h1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule